// File: doc/BRIEF.md
# USART SPI Master/Slave Port

This block is the SPI side of a serial port that reuses the pins of an asynchronous port. A 4-bit mode code picks the role. In master mode the block drives the serial clock from a programmable divider. It frames each 8-bit character with its single active-low select line, which leaves the handshake-output pin. In slave mode it oversamples an external serial clock. An incoming active-low select on the handshake-input pin qualifies each character, and the data pin that returns data to the master is tri-stated whenever that select is high.

Software writes the mode code and the 16-bit divisor together through a one-cycle configuration strobe. Parallel data leaves through a valid/ready pair and arrives as a one-cycle valid pulse. After the first configuration following hardware reset, any write that changes the mode locks the port. While locked, the port refuses data and ignores the select. Both the transmitter soft reset and the receiver soft reset must be pulsed, in either order, to lift the lock.

The master engine runs the states M_IDLE, M_LEAD, M_HIGH, M_LOW and M_TRAIL:
- M_IDLE goes to M_LEAD when a character is accepted.
- M_LEAD goes to M_HIGH when the half-bit count expires, which is the first rising edge.
- M_HIGH goes to M_LOW on a falling edge before the eighth bit, and to M_TRAIL on the falling edge after the eighth bit.
- M_LOW goes to M_HIGH on the next rising edge.
- M_TRAIL goes to M_IDLE when it releases the select.

The slave engine runs the states S_IDLE, S_SHIFT and S_HOLD:
- S_IDLE goes to S_SHIFT on a detected select fall while the port is unlocked.
- S_SHIFT goes to S_HOLD on the eighth detected rising clock edge, and back to S_IDLE on an early select rise, which is an abort.
- S_HOLD goes to S_IDLE on the select rise.

A soft reset or a mode-changing write forces both engines back to idle.

Top module: `usart_spi_port`

## Requirements
- R1: Mode code 4'hE selects SPI master and 4'hF selects SPI slave. The mode code is 4'h0 after reset. With any code other than 4'hE or 4'hF, `tx_ready`, `txd_oe` and `sck_oe` stay low and `rts_o` stays high.
- R2: In master mode `txd_oe` and `sck_oe` are high, `txd_o` carries outgoing data, and `rxd_i` is the incoming data. `rts_o` is the only select: it is high when idle and low for the whole of each character. `sck_o` is low whenever `rts_o` is high.
- R3: In slave mode `sck_oe` is low and `sck_i` is the clock. `cts_i` is the active-low select, `rxd_i` is the incoming data and `txd_o` is the outgoing data. `txd_oe` is high only while the synchronized select is low and the port is unlocked.
- R4: In master mode with divisor CD ≥ 1, a half bit lasts max(CD,2) clock cycles. The first rising `sck_o` edge comes one half bit after `rts_o` falls. Exactly 8 clock periods make up a character, so `sck_o` is high for 8 half bits. `rts_o` rises one half bit after the last falling edge, which is 17 half bits after it fell.
- R5: In master mode with CD = 0, `tx_ready` is low and no transfer starts.
- R6: Characters move MSB first. Incoming data is sampled on the rising clock edge and outgoing data changes on the falling edge. In master mode `rx_valid` pulses for exactly one cycle, with the received byte on `rx_data`, in the cycle `rts_o` rises.
- R7: In slave mode a byte accepted through `tx_valid`/`tx_ready` while the select is high is shifted out during the next select-low period. If no byte was offered, 8'hFF is shifted out. `rx_valid` pulses once after the eighth detected rising edge, and only one character is taken per select assertion.
- R8: In slave mode, a select rise before eight rising edges discards the character, so no `rx_valid` is produced, and sets `abort_flag`. Only a receiver soft reset clears `abort_flag`.
- R9: The first configuration write after reset never locks. A later write with a different mode code locks the port. While locked, `tx_ready` is low and a slave select is ignored. The lock lifts only after both `tx_srst` and `rx_srst` have been pulsed. A write that keeps the same mode, such as a divisor change, does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 4 | Mode code to write |
| cfg_div | input | DIV_W | Clock divisor to write |
| tx_srst | input | 1 | Transmitter soft reset pulse |
| rx_srst | input | 1 | Receiver soft reset pulse |
| tx_data | input | DATA_W | Character to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Port accepts tx_data |
| rx_data | output | DATA_W | Received character |
| rx_valid | output | 1 | One-cycle pulse with rx_data |
| abort_flag | output | 1 | Sticky slave abort indication |
| txd_o | output | 1 | Serial data pin output |
| txd_oe | output | 1 | Serial data pin output enable |
| rxd_i | input | 1 | Serial data pin input |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock input |
| rts_o | output | 1 | Active-low select output (master) |
| cts_i | input | 1 | Active-low select input (slave) |

## Verification
The bench measures the select-to-first-edge lead, the total high time and the select-release point. A design whose divider is off by one, or that misses the divisor clamp, would release the select in the wrong cycle. A port that locks on its first configuration or on a divisor-only write would never accept data. A port that unlocks after only one soft reset would report ready too early. In slave mode the bench checks that the all-ones filler appears when no byte was offered, and that the data pin floats while locked. It also cuts a character short: a design that still delivers the partial byte, or never raises the abort flag, shows up as a wrong receive count or flag value.

// File: rtl/usp_pkg.sv
`timescale 1ns/1ps
package usp_pkg;
    localparam logic [3:0] MODE_SPI_MST = 4'hE;
    localparam logic [3:0] MODE_SPI_SLV = 4'hF;

    typedef enum logic [2:0] {M_IDLE, M_LEAD, M_HIGH, M_LOW, M_TRAIL} mst_state_e;
    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_HOLD} slv_state_e;
endpackage

// File: rtl/usp_cfg.sv
`timescale 1ns/1ps
module usp_cfg #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_mode,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_srst,
    input  logic             rx_srst,
    output logic [3:0]       mode_q,
    output logic [DIV_W-1:0] div_eff,
    output logic             div_zero,
    output logic             locked,
    output logic             mode_chg
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    logic [DIV_W-1:0] div_q;
    logic             seen_q;
    logic             pend_tx_q;
    logic             pend_rx_q;

    assign mode_chg = cfg_we && (cfg_mode != mode_q);
    assign div_eff  = (div_q < DIV_MIN) ? DIV_MIN : div_q;
    assign div_zero = (div_q == '0);
    assign locked   = pend_tx_q || pend_rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 4'h0;
            div_q     <= '0;
            seen_q    <= 1'b0;
            pend_tx_q <= 1'b0;
            pend_rx_q <= 1'b0;
        end else begin
            if (tx_srst) pend_tx_q <= 1'b0;
            if (rx_srst) pend_rx_q <= 1'b0;
            if (cfg_we) begin
                mode_q <= cfg_mode;
                div_q  <= cfg_div;
                seen_q <= 1'b1;
                if (mode_chg && seen_q) begin
                    pend_tx_q <= 1'b1;
                    pend_rx_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/usp_master.sv
`timescale 1ns/1ps
module usp_master
    import usp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_eff,
    input  logic              div_zero,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    mst_state_e        state, state_d;
    logic [DIV_W-1:0]  hcnt;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] sh_tx, sh_rx;
    logic              half_done, start;

    assign half_done = (hcnt == '0);
    assign tx_ready  = en && !div_zero && !clr && (state == M_IDLE);
    assign start     = tx_valid && tx_ready;
    assign mosi_o    = sh_tx[DATA_W-1];

    always_comb begin
        state_d = state;
        unique case (state)
            M_IDLE:  if (start)     state_d = M_LEAD;
            M_LEAD:  if (half_done) state_d = M_HIGH;
            M_HIGH:  if (half_done) state_d = (bitcnt == LAST_BIT) ? M_TRAIL : M_LOW;
            M_LOW:   if (half_done) state_d = M_HIGH;
            M_TRAIL: if (half_done) state_d = M_IDLE;
            default:                state_d = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= M_IDLE;
        else if (clr) state <= M_IDLE;
        else          state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt     <= '0;
            bitcnt   <= '0;
            sh_tx    <= '0;
            sh_rx    <= '0;
            sck_o    <= 1'b0;
            ss_n_o   <= 1'b1;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                hcnt   <= '0;
                bitcnt <= '0;
                sck_o  <= 1'b0;
                ss_n_o <= 1'b1;
            end else begin
                if (state_d != state)    hcnt <= div_eff - 1'b1;
                else if (state != M_IDLE) hcnt <= hcnt - 1'b1;
                unique case (state)
                    M_IDLE: if (start) begin
                        sh_tx  <= tx_data;
                        ss_n_o <= 1'b0;
                        bitcnt <= '0;
                    end
                    M_LEAD, M_LOW: if (half_done) begin
                        sck_o <= 1'b1;
                        sh_rx <= {sh_rx[DATA_W-2:0], miso_i};
                    end
                    M_HIGH: if (half_done) begin
                        sck_o <= 1'b0;
                        if (bitcnt != LAST_BIT) begin
                            bitcnt <= bitcnt + 1'b1;
                            sh_tx  <= {sh_tx[DATA_W-2:0], 1'b0};
                        end
                    end
                    M_TRAIL: if (half_done) begin
                        ss_n_o   <= 1'b1;
                        rx_valid <= 1'b1;
                        rx_data  <= sh_rx;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/usp_slave.sv
`timescale 1ns/1ps
module usp_slave
    import usp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              clr_abort,
    input  logic              en,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              miso_o,
    output logic              drive_o,
    output logic              cs_sync_o,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              abort_o
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    slv_state_e        state, state_d;
    logic [SYNC_STAGES:0] sck_p, cs_p;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] sh_tx, sh_rx;
    logic              loaded;
    logic              sck_rise, sck_fall, cs_rise, cs_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
        end else begin
            sck_p <= {sck_p[SYNC_STAGES-1:0], sck_i};
            cs_p  <= {cs_p[SYNC_STAGES-1:0], cs_n_i};
        end
    end

    assign sck_rise  =  sck_p[SYNC_STAGES-1] && !sck_p[SYNC_STAGES];
    assign sck_fall  = !sck_p[SYNC_STAGES-1] &&  sck_p[SYNC_STAGES];
    assign cs_rise   =  cs_p[SYNC_STAGES-1]  && !cs_p[SYNC_STAGES];
    assign cs_fall   = !cs_p[SYNC_STAGES-1]  &&  cs_p[SYNC_STAGES];
    assign cs_sync_o =  cs_p[SYNC_STAGES-1];
    assign tx_ready  = en && !clr && (state == S_IDLE) && cs_sync_o && !loaded;
    assign drive_o   = en && !cs_sync_o;
    assign miso_o    = sh_tx[DATA_W-1];

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:  if (en && cs_fall) state_d = S_SHIFT;
            S_SHIFT: if (cs_rise) state_d = S_IDLE;
                     else if (sck_rise && bitcnt == LAST_BIT) state_d = S_HOLD;
            S_HOLD:  if (cs_rise) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= S_IDLE;
        else if (clr) state <= S_IDLE;
        else          state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            sh_tx    <= '1;
            sh_rx    <= '0;
            loaded   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            abort_o  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (clr) begin
                bitcnt <= '0;
                loaded <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (tx_valid && tx_ready) begin
                            sh_tx  <= tx_data;
                            loaded <= 1'b1;
                        end
                        if (en && cs_fall) begin
                            bitcnt <= '0;
                            loaded <= 1'b0;
                            if (!loaded) sh_tx <= '1;
                        end
                    end
                    S_SHIFT: begin
                        if (cs_rise) begin
                            abort_o <= 1'b1;
                        end else begin
                            if (sck_rise) begin
                                sh_rx <= {sh_rx[DATA_W-2:0], mosi_i};
                                if (bitcnt == LAST_BIT) begin
                                    rx_valid <= 1'b1;
                                    rx_data  <= {sh_rx[DATA_W-2:0], mosi_i};
                                end else begin
                                    bitcnt <= bitcnt + 1'b1;
                                end
                            end
                            if (sck_fall) sh_tx <= {sh_tx[DATA_W-2:0], 1'b1};
                        end
                    end
                    default: ;
                endcase
            end
            if (clr_abort) abort_o <= 1'b0;
        end
    end
endmodule

// File: rtl/usart_spi_port.sv
`timescale 1ns/1ps
module usart_spi_port
    import usp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_mode,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_srst,
    input  logic              rx_srst,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              abort_flag,
    output logic              txd_o,
    output logic              txd_oe,
    input  logic              rxd_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              rts_o,
    input  logic              cts_i
);
    logic [3:0]        mode_q;
    logic [DIV_W-1:0]  div_eff;
    logic              div_zero, locked, mode_chg, clr;
    logic              is_mst, is_slv;
    logic              m_ready, m_mosi, m_sck, m_ss_n, m_rx_valid;
    logic              s_ready, s_miso, s_drive, slv_cs_sync, s_rx_valid;
    logic [DATA_W-1:0] m_rx_data, s_rx_data;

    assign is_mst = (mode_q == MODE_SPI_MST);
    assign is_slv = (mode_q == MODE_SPI_SLV);
    assign clr    = tx_srst || rx_srst || mode_chg;

    usp_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_div(cfg_div), .tx_srst(tx_srst), .rx_srst(rx_srst),
        .mode_q(mode_q), .div_eff(div_eff), .div_zero(div_zero),
        .locked(locked), .mode_chg(mode_chg)
    );

    usp_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mst (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(is_mst && !locked),
        .div_eff(div_eff), .div_zero(div_zero),
        .tx_data(tx_data), .tx_valid(tx_valid && is_mst), .tx_ready(m_ready),
        .miso_i(rxd_i), .mosi_o(m_mosi), .sck_o(m_sck), .ss_n_o(m_ss_n),
        .rx_data(m_rx_data), .rx_valid(m_rx_valid)
    );

    usp_slave #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_slv (
        .clk(clk), .rst_n(rst_n), .clr(clr), .clr_abort(rx_srst),
        .en(is_slv && !locked), .sck_i(sck_i), .cs_n_i(cts_i), .mosi_i(rxd_i),
        .tx_data(tx_data), .tx_valid(tx_valid && is_slv), .tx_ready(s_ready),
        .miso_o(s_miso), .drive_o(s_drive), .cs_sync_o(slv_cs_sync),
        .rx_data(s_rx_data), .rx_valid(s_rx_valid), .abort_o(abort_flag)
    );

    assign tx_ready = (is_mst && m_ready) || (is_slv && s_ready);
    assign rx_valid = m_rx_valid || s_rx_valid;
    assign rx_data  = m_rx_valid ? m_rx_data : s_rx_data;
    assign txd_o    = is_mst ? m_mosi : s_miso;
    assign txd_oe   = is_mst || (is_slv && s_drive);
    assign sck_o    = is_mst && m_sck;
    assign sck_oe   = is_mst;
    assign rts_o    = is_mst ? m_ss_n : 1'b1;
endmodule

// File: rtl/usart_spi_port_chk.sv
`timescale 1ns/1ps
module usart_spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode,
    input logic       locked,
    input logic       div_zero,
    input logic       cs_sync,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       txd_oe,
    input logic       sck_oe,
    input logic       sck_o,
    input logic       rts_o
);
    a_r1_other_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 4'hE && mode != 4'hF) |-> (!tx_ready && !txd_oe && !sck_oe && rts_o));

    a_r2_master_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'hE) |-> (sck_oe && txd_oe));

    a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'hE && rts_o) |-> !sck_o);

    a_r3_slave_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'hF && cs_sync) |-> !txd_oe);

    a_r5_div_zero_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'hE && div_zero) |-> !tx_ready);

    a_r6_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r9_locked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !tx_ready);
endmodule

bind usart_spi_port usart_spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .locked(locked),
    .div_zero(div_zero), .cs_sync(slv_cs_sync), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .txd_oe(txd_oe), .sck_oe(sck_oe),
    .sck_o(sck_o), .rts_o(rts_o)
);

// File: tb/test_usart_spi_port.sv
`timescale 1ns/1ps
module test_usart_spi_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = 4'h0;
    logic [15:0] cfg_div = 16'd0;
    logic        tx_srst = 1'b0, rx_srst = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid, abort_flag;
    logic        txd_o, txd_oe, sck_o, sck_oe, rts_o;
    logic        rxd = 1'b0, sck_in = 1'b0, cts = 1'b1;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;

    always #2 clk = ~clk;

    usart_spi_port i_usart_spi_port (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_div(cfg_div), .tx_srst(tx_srst), .rx_srst(rx_srst),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .abort_flag(abort_flag),
        .txd_o(txd_o), .txd_oe(txd_oe), .rxd_i(rxd), .sck_o(sck_o),
        .sck_oe(sck_oe), .sck_i(sck_in), .rts_o(rts_o), .cts_i(cts)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic configure(input logic [3:0] m, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_div = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_srst(input bit tx, input bit rx);
        @(negedge clk);
        tx_srst = tx; rx_srst = rx;
        @(negedge clk);
        tx_srst = 1'b0; rx_srst = 1'b0;
    endtask

    task automatic master_xfer(input logic [7:0] d, input logic [7:0] m, input int eff);
        int cyc = 0, first = -1, hi = 0, rises = 0, rel = -1, bi = 1, rxc0;
        logic [7:0] cap = 8'h00;
        logic prev = 1'b0;
        rxc0 = rx_cnt;
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        rxd = m[7];
        chk("R2 select low during character", rts_o, 0);
        while (rel < 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (sck_o && !prev) begin
                rises++;
                cap = {cap[6:0], txd_o};
                if (first < 0) first = cyc;
            end
            if (!sck_o && prev && bi < 8) begin
                rxd = m[7 - bi];
                bi++;
            end
            if (sck_o) hi++;
            if (rts_o) rel = cyc;
            prev = sck_o;
        end
        @(negedge clk);
        chk("R4 lead before first edge", first, eff);
        chk("R4 rising edges per char", rises, 8);
        chk("R4 high time", hi, 8 * eff);
        chk("R4 select release point", rel, 17 * eff);
        chk("R6 MSB-first outgoing byte", cap, d);
        chk("R6 one rx pulse", rx_cnt, rxc0 + 1);
        chk("R6 received byte", rx_last, m);
    endtask

    task automatic slave_xfer(input logic [7:0] mo, input int nbits, input bit preload,
                              input logic [7:0] pd, input bit expect_rx, input logic [7:0] exp_mi);
        int rxc0;
        logic [7:0] cap = 8'h00;
        if (preload) begin
            @(negedge clk);
            tx_data = pd; tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
        end
        rxc0 = rx_cnt;
        @(negedge clk);
        cts = 1'b0;
        repeat (8) @(negedge clk);
        if (nbits == 8) chk("R3 data pin enable with select low", txd_oe, expect_rx ? 1 : 0);
        for (int i = 0; i < nbits; i++) begin
            rxd = mo[7 - i];
            repeat (4) @(negedge clk);
            sck_in = 1'b1;
            cap = {cap[6:0], txd_o};
            repeat (8) @(negedge clk);
            sck_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        cts = 1'b1;
        repeat (8) @(negedge clk);
        if (nbits == 8) begin
            if (expect_rx) begin
                chk("R7 one rx pulse per select", rx_cnt, rxc0 + 1);
                chk("R7 received byte", rx_last, mo);
                chk("R7 shifted-out byte", cap, exp_mi);
            end else begin
                chk("R9 locked slave ignores select", rx_cnt, rxc0);
            end
        end
    endtask

    task automatic test_reset;
        chk("R1 reset tx_ready", tx_ready, 0);
        chk("R1 reset rts_o", rts_o, 1);
        chk("R1 reset txd_oe", txd_oe, 0);
        chk("R1 reset sck_oe", sck_oe, 0);
        chk("R8 reset abort_flag", abort_flag, 0);
    endtask

    task automatic test_master;
        configure(4'hE, 16'd3);
        @(negedge clk);
        chk("R2 master sck_oe", sck_oe, 1);
        chk("R2 master txd_oe", txd_oe, 1);
        chk("R2 idle select high", rts_o, 1);
        chk("R9 first config does not lock", tx_ready, 1);
        master_xfer(8'hA5, 8'h3C, 3);
        master_xfer(8'h81, 8'hFF, 3);
        configure(4'hE, 16'd1);
        @(negedge clk);
        chk("R9 same-mode write does not lock", tx_ready, 1);
        master_xfer(8'h5A, 8'h00, 2);
    endtask

    task automatic test_div_zero;
        configure(4'hE, 16'd0);
        @(negedge clk);
        chk("R5 zero divisor blocks ready", tx_ready, 0);
        tx_data = 8'h77; tx_valid = 1'b1;
        repeat (20) @(negedge clk);
        tx_valid = 1'b0;
        chk("R5 zero divisor no select", rts_o, 1);
    endtask

    task automatic test_lock;
        configure(4'hF, 16'd0);
        @(negedge clk);
        chk("R9 mode change locks", tx_ready, 0);
        chk("R3 slave sck_oe low", sck_oe, 0);
        slave_xfer(8'h3C, 8, 1'b0, 8'h00, 1'b0, 8'h00);
        pulse_srst(1'b1, 1'b0);
        @(negedge clk);
        chk("R9 one soft reset keeps lock", tx_ready, 0);
        pulse_srst(1'b0, 1'b1);
        @(negedge clk);
        chk("R9 both soft resets unlock", tx_ready, 1);
        chk("R3 data pin floats with select high", txd_oe, 0);
    endtask

    task automatic test_slave;
        slave_xfer(8'h96, 8, 1'b1, 8'hC3, 1'b1, 8'hC3);
        slave_xfer(8'h0F, 8, 1'b0, 8'h00, 1'b1, 8'hFF);
    endtask

    task automatic test_abort;
        int rxc0;
        rxc0 = rx_cnt;
        slave_xfer(8'hF0, 4, 1'b0, 8'h00, 1'b1, 8'h00);
        chk("R8 abort flag set", abort_flag, 1);
        chk("R8 partial char discarded", rx_cnt, rxc0);
        pulse_srst(1'b1, 1'b0);
        @(negedge clk);
        chk("R8 tx soft reset keeps abort", abort_flag, 1);
        pulse_srst(1'b0, 1'b1);
        @(negedge clk);
        chk("R8 rx soft reset clears abort", abort_flag, 0);
    endtask

    task automatic test_other_mode;
        configure(4'h3, 16'd4);
        @(negedge clk);
        chk("R1 other mode tx_ready", tx_ready, 0);
        chk("R1 other mode sck_oe", sck_oe, 0);
        chk("R1 other mode txd_oe", txd_oe, 0);
        chk("R1 other mode rts_o", rts_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_master();
        test_div_zero();
        test_lock();
        test_slave();
        test_abort();
        test_other_mode();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule